// File: doc/BRIEF.md
# Sampling Converter Bus Interface Controller

This block is the digital side of a 12-bit sampling converter that sits on a microprocessor bus. It takes the bus strobes and produces three things: a hold command for the track/hold stage, a single active-low status line, and the conversion result on a data bus. A conversion can be started in two ways. In interrupt mode, the processor pulses a dedicated convert strobe. The status line then falls when the result is ready, and it rises again on the first read. In slow-memory mode, the convert strobe is held low and the chip-select edge starts the conversion. The status line then acts as a BUSY wait signal for the whole conversion, so one bus read can start a conversion, stall, and then return the result.

The analog path is replaced by a behavioural stand-in. The value on `samp_in` is captured on the clock edge that starts a conversion, and it is handed over as the result a fixed number of clocks later. The result can be read as one 12-bit word, or as a low byte and a high byte chosen by a byte-select input. The bus is driven only during a read. The tri-state is modelled as an enable signal, and the data lines read zero when the enable is off.

All bus strobes are sampled on the rising clock edge. A falling edge is seen when a line was high at one edge and is low at the next.

Top module: `adc_bus_ctrl`

## Requirements
- R1: While reset is high and just after it, `hold` is 0 and `stat_n` is 1, and the stored result is zero, so a word read returns 0.
- R2: A falling edge on `conv_n` while idle starts a conversion. `hold` is 1 from the next edge for exactly CONV_CYC clock cycles, then returns to 0.
- R3: In a conversion started by `conv_n`, `stat_n` stays 1 while converting and goes to 0 on the same edge that `hold` falls.
- R4: After an interrupt-mode conversion, `stat_n` stays 0 until the first edge that sees `cs_n` and `rd_n` both low after they were not both low. Chip select alone does not release it. That edge sets `stat_n` to 1.
- R5: With `conv_n` low, a falling edge on `cs_n` while `byte_hi` is 0 starts a conversion. The same edge with `byte_hi` = 1 starts nothing.
- R6: In a conversion started by chip select, `stat_n` goes to 0 on the start edge, stays 0 while `hold` is 1, and returns to 1 on the edge that `hold` falls.
- R7: The result equals `samp_in` as sampled on the start edge. Changes to `samp_in` during the hold have no effect on it.
- R8: With `word_sel` = 1 and a read active, `dout[11:0]` is the whole 12-bit result.
- R9: With `word_sel` = 0 and a read active, `byte_hi` = 0 gives result bits 7:0 on `dout[7:0]`. `byte_hi` = 1 gives result bits 11:8 on `dout[3:0]`. All other `dout` bits are 0.
- R10: `dout_oe` is 1 exactly while `cs_n` and `rd_n` are both low. When it is 0, `dout` is all zeros.
- R11: A start request (a `conv_n` edge, or a chip-select start) that arrives while `hold` is 1 is ignored. The running conversion keeps its timing and its captured value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_n | input | 1 | Convert strobe; a falling edge starts a conversion, and holding it low selects slow-memory starts |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| byte_hi | input | 1 | Byte select for byte reads; must be 0 for a chip-select start |
| word_sel | input | 1 | 1: 12-bit word output, 0: byte output |
| samp_in | input | 12 | Value the stand-in converter captures at start |
| hold | output | 1 | Track/hold command, 1 = hold |
| stat_n | output | 1 | Combined interrupt / BUSY status, active low |
| dout | output | 12 | Read data |
| dout_oe | output | 1 | Data bus drive enable |

## Verification
A start strobe applied before a rising edge shows up on `hold` one cycle later. `hold` then stays high for CONV_CYC cycles, and `stat_n` and the result both change on the edge where it falls. A read-release of the interrupt also appears one edge after the strobes go low. `dout` and `dout_oe` follow the strobes and `byte_hi` with no register, so the bench checks them 1 ns after it drives a change. It checks every registered output on the falling edge that follows the rising edge it is due on. The hold window is measured by counting falling edges from the start, so an early or late drop of `hold` lands on a sample point.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

    localparam int RES_W  = 12;
    localparam int BYTE_W = 8;
    localparam int HI_W   = RES_W - BYTE_W;

    typedef logic [RES_W-1:0] result_t;

    typedef enum logic {
        START_IRQ  = 1'b0,
        START_SLOW = 1'b1
    } start_mode_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic acc_fall;
        logic cs_fall;
        logic conv_fall;
    } bus_edges_t;

    function automatic result_t pick_field(input result_t res, input logic word, input logic hi);
        result_t r;
        if (word)
            r = res;
        else if (hi)
            r = {{(RES_W-HI_W){1'b0}}, res[RES_W-1:BYTE_W]};
        else
            r = {{(RES_W-BYTE_W){1'b0}}, res[BYTE_W-1:0]};
        return r;
    endfunction

endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_n,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                prev_q[i] <= 1'b1;
            else
                prev_q[i] <= lvl_n[i];
        end
        assign fall[i] = prev_q[i] & ~lvl_n[i];
    end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_bus_pkg::*;
#(
    parameter int CONV_CYC = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_edges_t edges,
    input  logic       conv_lvl_n,
    input  logic       byte_hi,
    output logic       hold,
    output logic       stat_n,
    output logic       start_p,
    output logic       done_p
);
    localparam int CNT_W = $clog2(CONV_CYC + 1);

    seq_state_e  state;
    start_mode_e mode;
    logic [CNT_W-1:0] cnt;
    logic slow_req;
    logic start_req;

    assign slow_req  = edges.cs_fall & ~conv_lvl_n & ~byte_hi;
    assign start_req = edges.conv_fall | slow_req;
    assign start_p   = (state == SEQ_IDLE) && start_req;
    assign done_p    = (state == SEQ_CONV) && (cnt == '0);
    assign hold      = (state == SEQ_CONV);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            mode   <= START_IRQ;
            cnt    <= '0;
            stat_n <= 1'b1;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start_req) begin
                        state  <= SEQ_CONV;
                        cnt    <= CNT_W'(CONV_CYC - 1);
                        mode   <= edges.conv_fall ? START_IRQ : START_SLOW;
                        stat_n <= edges.conv_fall;
                    end else if (edges.acc_fall) begin
                        stat_n <= 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        state  <= SEQ_IDLE;
                        stat_n <= (mode == START_SLOW);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    assert_hold_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_CONV && cnt != '0) |=> (state == SEQ_CONV));

    assert_irq_on_end_R3: assert property (@(posedge clk) disable iff (rst)
        (done_p && mode == START_IRQ) |=> !stat_n);

    assert_busy_low_R6: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_CONV && mode == START_SLOW) |-> !stat_n);

    assert_no_restart_R11: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_CONV && start_req && cnt != '0) |=>
            (state == SEQ_CONV && mode == $past(mode) && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/adc_sample_hold.sv
module adc_sample_hold
    import adc_bus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_p,
    input  logic    done_p,
    input  logic    hold,
    input  result_t samp_in,
    output result_t result
);
    result_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            result <= '0;
        end else begin
            if (start_p)
                held_q <= samp_in;
            if (done_p)
                result <= held_q;
        end
    end

    assert_result_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (hold && !done_p) |=> $stable(result));

    assert_held_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold)) |-> $stable(held_q));
endmodule

// File: rtl/adc_bus_out.sv
module adc_bus_out
    import adc_bus_pkg::*;
(
    input  logic    cs_n,
    input  logic    rd_n,
    input  logic    word_sel,
    input  logic    byte_hi,
    input  result_t result,
    output result_t dout,
    output logic    dout_oe
);
    always_comb begin
        dout_oe = ~cs_n & ~rd_n;
        dout    = dout_oe ? pick_field(result, word_sel, byte_hi) : '0;
    end

    always_comb begin
        if (dout_oe && !word_sel)
            assert_byte_narrow_R9: assert (dout[RES_W-1:BYTE_W] == '0);
    end
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
    import adc_bus_pkg::*;
#(
    parameter int CONV_CYC = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             byte_hi,
    input  logic             word_sel,
    input  logic [RES_W-1:0] samp_in,
    output logic             hold,
    output logic             stat_n,
    output logic [RES_W-1:0] dout,
    output logic             dout_oe
);
    logic [2:0] falls;
    bus_edges_t edges;
    logic       start_p;
    logic       done_p;
    result_t    result;

    adc_edge_det #(.N(3)) u_edges (
        .clk   (clk),
        .rst   (rst),
        .lvl_n ({cs_n | rd_n, cs_n, conv_n}),
        .fall  (falls)
    );

    assign edges = bus_edges_t'(falls);

    adc_conv_seq #(.CONV_CYC(CONV_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .edges      (edges),
        .conv_lvl_n (conv_n),
        .byte_hi    (byte_hi),
        .hold       (hold),
        .stat_n     (stat_n),
        .start_p    (start_p),
        .done_p     (done_p)
    );

    adc_sample_hold u_sh (
        .clk     (clk),
        .rst     (rst),
        .start_p (start_p),
        .done_p  (done_p),
        .hold    (hold),
        .samp_in (samp_in),
        .result  (result)
    );

    adc_bus_out u_out (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .word_sel (word_sel),
        .byte_hi  (byte_hi),
        .result   (result),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    assert_read_release_R4: assert property (@(posedge clk) disable iff (rst)
        (!stat_n && !hold && (cs_n || rd_n) && !(edges.conv_fall)) |=> !stat_n);
endmodule

// File: tb/test_adc_bus_ctrl.sv
`timescale 1ns/1ps
module test_adc_bus_ctrl;
    localparam int C = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        byte_hi = 1'b0;
    logic        word_sel = 1'b1;
    logic [11:0] samp_in = '0;
    logic        hold;
    logic        stat_n;
    logic [11:0] dout;
    logic        dout_oe;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    adc_bus_ctrl #(.CONV_CYC(C)) i_adc_bus_ctrl (
        .clk(clk), .rst(rst), .conv_n(conv_n), .cs_n(cs_n), .rd_n(rd_n),
        .byte_hi(byte_hi), .word_sel(word_sel), .samp_in(samp_in),
        .hold(hold), .stat_n(stat_n), .dout(dout), .dout_oe(dout_oe)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            $display("FAIL R2 watchdog expired actual=%0d expected<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_irq(input logic [11:0] v, input bit retry, input bit first_hi);
        bit ok;
        @(negedge clk); samp_in = v; conv_n = 1'b0;
        @(negedge clk);
        chk("R2 hold after strobe", hold, 1);
        chk("R3 status high while converting", stat_n, 1);
        conv_n = 1'b1; samp_in = ~v;
        ok = 1;
        for (int k = 2; k <= C; k++) begin
            @(negedge clk);
            if (retry && k == 3) begin conv_n = 1'b0; samp_in = v ^ 12'h5a5; end
            if (retry && k == 4) conv_n = 1'b1;
            if (hold !== 1'b1 || stat_n !== 1'b1) ok = 0;
        end
        chk(retry ? "R11 restart ignored, hold window" : "R2 hold window", ok, 1);
        @(negedge clk);
        chk("R2 hold drops", hold, 0);
        chk("R3 status low at end", stat_n, 0);
        cs_n = 1'b0;
        @(negedge clk);
        chk("R4 chip select alone keeps status", stat_n, 0);
        chk("R10 no drive without read", dout_oe, 0);
        chk("R10 bus zero when idle", dout, 0);
        rd_n = 1'b0; word_sel = 1'b0; byte_hi = first_hi;
        #1;
        chk("R10 drive during read", dout_oe, 1);
        chk("R9 first byte", dout, first_hi ? {8'h0, v[11:8]} : {4'h0, v[7:0]});
        chk("R4 status before edge", stat_n, 0);
        @(negedge clk);
        chk("R4 status released by read", stat_n, 1);
        chk(retry ? "R11 no extra conversion" : "R2 idle after read", hold, 0);
        byte_hi = ~first_hi;
        #1;
        chk("R9 second byte", dout, first_hi ? {4'h0, v[7:0]} : {8'h0, v[11:8]});
        word_sel = 1'b1;
        #1;
        chk("R8 R7 word read", dout, v);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; byte_hi = 1'b0;
        #1;
        chk("R10 release", {dout_oe, dout}, 0);
    endtask

    task automatic run_slow(input logic [11:0] v, input bit retry);
        bit ok;
        @(negedge clk); samp_in = v; word_sel = 1'b1; byte_hi = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk("R5 chip select start", hold, 1);
        chk("R6 busy low at start", stat_n, 0);
        samp_in = ~v;
        ok = 1;
        for (int k = 2; k <= C; k++) begin
            @(negedge clk);
            if (retry && k == 3) begin cs_n = 1'b1; rd_n = 1'b1; end
            if (retry && k == 4) begin cs_n = 1'b0; rd_n = 1'b0; samp_in = v ^ 12'h3c3; end
            if (hold !== 1'b1 || stat_n !== 1'b0) ok = 0;
        end
        chk(retry ? "R11 chip select restart ignored" : "R6 busy window", ok, 1);
        @(negedge clk);
        chk("R6 hold drops", hold, 0);
        chk("R6 busy released", stat_n, 1);
        chk("R8 R7 word after wait", {dout_oe, dout}, {1'b1, v});
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        byte_hi = 1'b1; word_sel = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
        #1;
        chk("R9 high byte slow", dout, {8'h0, v[11:8]});
        @(negedge clk);
        chk("R5 no start with byte select high", hold, 0);
        chk("R6 status stays high", stat_n, 1);
        cs_n = 1'b1; rd_n = 1'b1; byte_hi = 1'b0; word_sel = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 hold in reset", hold, 0);
        chk("R1 status in reset", stat_n, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 hold after reset", hold, 0);
        chk("R1 status after reset", stat_n, 1);
        cs_n = 1'b0; rd_n = 1'b0; word_sel = 1'b1;
        #1;
        chk("R1 result zero", {dout_oe, dout}, {1'b1, 12'h000});
        @(negedge clk);
        chk("R1 read does not start", hold, 0);
        cs_n = 1'b1; rd_n = 1'b1;

        for (int i = 0; i < 4096; i += 273)
            run_irq(12'(i), (i % 2) == 1, (i % 3) == 0);
        run_irq(12'hfff, 1'b1, 1'b1);
        run_irq(12'h800, 1'b0, 1'b0);

        @(negedge clk); conv_n = 1'b0; samp_in = 12'h0;
        repeat (C + 2) @(negedge clk);
        chk("R3 entry conversion ends low", stat_n, 0);
        byte_hi = 1'b1; word_sel = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk("R5 byte select high no start", hold, 0);
        chk("R4 released on entry read", stat_n, 1);
        cs_n = 1'b1; rd_n = 1'b1; byte_hi = 1'b0; word_sel = 1'b1;

        for (int i = 0; i < 4096; i += 315)
            run_slow(12'(i ^ 12'h0a5), (i % 2) == 0);
        run_slow(12'hfff, 1'b0);
        run_slow(12'h001, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule